// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This unit sits on the path of physical byte addresses going to tiled surfaces in a memory with two interleaved channels. The channel is picked partly by address bit 6. Tiled accesses change the interleave pattern, so bit 6 of each tiled address is replaced by the XOR of bit 6 with a set of higher address bits. The X and Y tiling layouts each have their own set. Linear (untiled) accesses are not changed.

The unit also works out the X and Y swizzle modes from the memory configuration. There are two ways to do this, chosen by a select input. The first decodes a channel-control word, which gives the channel mode, a hash-disable flag and a select for the hash source bit. The second compares the populated sizes reported for the two channels. If the configuration cannot be trusted, both modes read back as "none" and a flag tells software to pin its pages.

There is one more adjustment, applied on top of the swizzle. It inverts bit 6, which exchanges the two 64-byte halves of every 128-byte block. This corrects pages whose bit 17 has changed since they were written. The address and the detected modes are registered, so they appear one cycle after the inputs.

Top module: `swz_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `addr_out`, `mode_x`, `mode_y` and `pin_pages` are all zero.
- R2: `addr_out`, `mode_x`, `mode_y` and `pin_pages` reflect the inputs sampled at the previous rising clock edge. No bit of `addr_out` other than bit 6 ever differs from the corresponding bit of the registered input address.
- R3: `addr_out` equals the previous cycle's `addr_in` in two cases. The first is when `en` was 0. The second is when `tile_in` was linear (code 0) or reserved (code 3) and `fixup_in` was 0.
- R4: Tile codes are 1 for X and 2 for Y. Bit 6 of an X-tiled address is XORed with the taps of `mode_x`, and bit 6 of a Y-tiled address with the taps of `mode_y`. The mode codes and their taps are: 0 none, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11, 5 bits 9 and 17, 6 bits 9, 10 and 17, 7 unknown.
- R5: With `cfg_sel`=0, the channel mode is `ctl_word[1:0]` (0 single, 1 asymmetric dual, 2 interleaved dual, 3 reserved). A value of 0 or 1 gives X=0 and Y=0.
- R6: With `cfg_sel`=0, interleaved mode and hash-disable `ctl_word[10]`=1, the modes are X=2 and Y=1.
- R7: With `cfg_sel`=0, interleaved mode and `ctl_word[10]`=0, the modes depend on `ctl_word[9]`. If it is 1 they are X=6 and Y=5; if it is 0 they are X=4 and Y=3.
- R8: With `cfg_sel`=1, equal `size_a` and `size_b` give X=2 and Y=1. Unequal sizes give X=0 and Y=0. In both cases `pin_pages` is 0.
- R9: With `cfg_sel`=0, either an all-ones `ctl_word` or the reserved channel mode gives X=0, Y=0 and `pin_pages`=1. The unknown code 7 never appears on `mode_x` or `mode_y`.
- R10: With `en`=1 and `fixup_in`=1, bit 6 is also inverted after any swizzle. This applies to every tile code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables swizzle and fixup |
| tile_in | input | 2 | Tiling of the access: 0 linear, 1 X, 2 Y, 3 reserved |
| fixup_in | input | 1 | Requests inversion of bit 6 to exchange 64-byte halves |
| addr_in | input | ADDR_W | Physical byte address |
| cfg_sel | input | 1 | 0: decode the channel-control word, 1: compare channel sizes |
| ctl_word | input | CTL_W | Channel-control word read back from the memory controller |
| size_a | input | SZ_W | Populated size reported for channel A |
| size_b | input | SZ_W | Populated size reported for channel B |
| addr_out | output | ADDR_W | Registered swizzled address |
| mode_x | output | 3 | Registered X swizzle mode |
| mode_y | output | 3 | Registered Y swizzle mode |
| pin_pages | output | 1 | Registered flag: configuration unknown, pages must stay put |

## Verification
The swizzled address, both modes and the pin flag are all due exactly one rising edge after the inputs that produce them. Each drive task sets the inputs on a falling edge and pushes one expected item. The monitor pops that item just after the next rising edge, which is the edge that registers it, and compares all four outputs. The reset check is sampled while reset is still held. Back-to-back stimuli therefore line up one-to-one with the scoreboard queue, with no gaps and no extra delay.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_mode_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_e;

    typedef enum logic [1:0] {
        CH_SINGLE = 2'd0,
        CH_ASYM   = 2'd1,
        CH_INTLV  = 2'd2,
        CH_RSVD   = 2'd3
    } chan_e;

    // Address bit positions involved in the channel hash
    localparam int unsigned TGT_BIT = 6;
    localparam int unsigned TAP_9   = 9;
    localparam int unsigned TAP_10  = 10;
    localparam int unsigned TAP_11  = 11;
    localparam int unsigned TAP_17  = 17;
    localparam int unsigned MIN_ADDR_W = TAP_17 + 1;

    // Control word field positions
    localparam int unsigned CTL_CH_LSB   = 0;
    localparam int unsigned CTL_HI17_BIT = 9;
    localparam int unsigned CTL_HOFF_BIT = 10;

    typedef struct packed {
        swz_mode_e x;
        swz_mode_e y;
        logic      pin;
    } swz_cfg_t;

    typedef struct packed {
        logic t17;
        logic t11;
        logic t10;
        logic t9;
    } swz_taps_t;

    function automatic swz_taps_t mode_taps(input swz_mode_e m);
        swz_taps_t t;
        t = '0;
        unique case (m)
            SWZ_9:       t.t9 = 1'b1;
            SWZ_9_10:    begin t.t9 = 1'b1; t.t10 = 1'b1; end
            SWZ_9_11:    begin t.t9 = 1'b1; t.t11 = 1'b1; end
            SWZ_9_10_11: begin t.t9 = 1'b1; t.t10 = 1'b1; t.t11 = 1'b1; end
            SWZ_9_17:    begin t.t9 = 1'b1; t.t17 = 1'b1; end
            SWZ_9_10_17: begin t.t9 = 1'b1; t.t10 = 1'b1; t.t17 = 1'b1; end
            default:     t = '0;
        endcase
        return t;
    endfunction

    // Unknown in either direction collapses to none and asks for pinned pages
    function automatic swz_cfg_t resolve_cfg(input swz_cfg_t raw);
        swz_cfg_t r;
        r = raw;
        if (raw.x == SWZ_UNKNOWN || raw.y == SWZ_UNKNOWN) begin
            r.x   = SWZ_NONE;
            r.y   = SWZ_NONE;
            r.pin = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/swz_detect.sv
module swz_detect
    import swz_pkg::*;
#(
    parameter int unsigned CTL_W = 32,
    parameter int unsigned SZ_W  = 16
) (
    input  logic             cfg_sel,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic [SZ_W-1:0]  size_a,
    input  logic [SZ_W-1:0]  size_b,
    output swz_cfg_t         cfg_o
);

    swz_cfg_t ctl_raw;
    swz_cfg_t size_raw;
    chan_e    ch;

    assign ch = chan_e'(ctl_word[CTL_CH_LSB +: 2]);

    always_comb begin
        ctl_raw = '{x: SWZ_NONE, y: SWZ_NONE, pin: 1'b0};
        unique case (ch)
            CH_SINGLE, CH_ASYM: ctl_raw = '{x: SWZ_NONE, y: SWZ_NONE, pin: 1'b0};
            CH_INTLV: begin
                if (ctl_word[CTL_HOFF_BIT])
                    ctl_raw = '{x: SWZ_9_10, y: SWZ_9, pin: 1'b0};
                else if (ctl_word[CTL_HI17_BIT])
                    ctl_raw = '{x: SWZ_9_10_17, y: SWZ_9_17, pin: 1'b0};
                else
                    ctl_raw = '{x: SWZ_9_10_11, y: SWZ_9_11, pin: 1'b0};
            end
            default: ctl_raw = '{x: SWZ_UNKNOWN, y: SWZ_UNKNOWN, pin: 1'b0};
        endcase
        // A failed readback returns all ones; treat as unknown
        if (&ctl_word)
            ctl_raw = '{x: SWZ_UNKNOWN, y: SWZ_UNKNOWN, pin: 1'b0};
    end

    always_comb begin
        if (size_a == size_b)
            size_raw = '{x: SWZ_9_10, y: SWZ_9, pin: 1'b0};
        else
            size_raw = '{x: SWZ_NONE, y: SWZ_NONE, pin: 1'b0};
    end

    assign cfg_o = resolve_cfg(cfg_sel ? size_raw : ctl_raw);

endmodule

// File: rtl/swz_bitcalc.sv
module swz_bitcalc
    import swz_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  tile_e             tile,
    input  swz_cfg_t          cfg,
    input  logic              en,
    input  logic              fixup,
    output logic              flip
);

    swz_mode_e sel_mode;
    swz_taps_t taps;
    logic      hash;

    always_comb begin
        unique case (tile)
            TILE_X:  sel_mode = cfg.x;
            TILE_Y:  sel_mode = cfg.y;
            default: sel_mode = SWZ_NONE;
        endcase
    end

    assign taps = mode_taps(sel_mode);

    assign hash = (taps.t9  & addr[TAP_9])
                ^ (taps.t10 & addr[TAP_10])
                ^ (taps.t11 & addr[TAP_11])
                ^ (taps.t17 & addr[TAP_17]);

    assign flip = en & (hash ^ fixup);

endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CTL_W  = 32,
    parameter int unsigned SZ_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        tile_in,
    input  logic              fixup_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cfg_sel,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic [SZ_W-1:0]   size_a,
    input  logic [SZ_W-1:0]   size_b,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        mode_x,
    output logic [2:0]        mode_y,
    output logic              pin_pages
);

    localparam logic [ADDR_W-1:0] TGT_MASK = ADDR_W'(1) << TGT_BIT;

    swz_cfg_t          cfg_d;
    swz_cfg_t          cfg_q;
    logic              flip;
    logic [ADDR_W-1:0] addr_q;

    generate
        if (ADDR_W < MIN_ADDR_W) begin : g_width_bad
            initial $error("swz_unit: ADDR_W too small for hash taps");
        end
    endgenerate

    swz_detect #(.CTL_W(CTL_W), .SZ_W(SZ_W)) u_detect (
        .cfg_sel  (cfg_sel),
        .ctl_word (ctl_word),
        .size_a   (size_a),
        .size_b   (size_b),
        .cfg_o    (cfg_d)
    );

    swz_bitcalc #(.ADDR_W(ADDR_W)) u_bitcalc (
        .addr  (addr_in),
        .tile  (tile_e'(tile_in)),
        .cfg   (cfg_d),
        .en    (en),
        .fixup (fixup_in),
        .flip  (flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cfg_q  <= '{x: SWZ_NONE, y: SWZ_NONE, pin: 1'b0};
        end else begin
            addr_q <= flip ? (addr_in ^ TGT_MASK) : addr_in;
            cfg_q  <= cfg_d;
        end
    end

    assign addr_out  = addr_q;
    assign mode_x    = cfg_q.x;
    assign mode_y    = cfg_q.y;
    assign pin_pages = cfg_q.pin;

endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CTL_W  = 32,
    parameter int unsigned SZ_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        tile_in,
    input logic              fixup_in,
    input logic [ADDR_W-1:0] addr_in,
    input logic              cfg_sel,
    input logic [CTL_W-1:0]  ctl_word,
    input logic [SZ_W-1:0]   size_a,
    input logic [SZ_W-1:0]   size_b,
    input logic [ADDR_W-1:0] addr_out,
    input logic [2:0]        mode_x,
    input logic [2:0]        mode_y,
    input logic              pin_pages
);

    // High once the previous edge registered real inputs
    logic primed = 1'b0;
    always_ff @(posedge clk) primed <= ~rst;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_out == '0 && mode_x == 3'd0 && mode_y == 3'd0 && !pin_pages)); // R1

    AST_ONLY_BIT6: assert property (@(posedge clk) disable iff (rst || !primed)
        (addr_out[ADDR_W-1:7] == $past(addr_in[ADDR_W-1:7]) &&
         addr_out[5:0] == $past(addr_in[5:0]))); // R2

    AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!en) |-> addr_out == $past(addr_in)); // R3

    AST_PASS_LINEAR: assert property (@(posedge clk) disable iff (rst || !primed)
        $past((tile_in == 2'd0 || tile_in == 2'd3) && !fixup_in) |-> addr_out == $past(addr_in)); // R3

    AST_SIZE_MISMATCH: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(cfg_sel && size_a != size_b) |-> (mode_x == 3'd0 && mode_y == 3'd0 && !pin_pages)); // R8

    AST_ALLONES_PIN: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!cfg_sel && (&ctl_word)) |-> pin_pages); // R9

    AST_PIN_MEANS_NONE: assert property (@(posedge clk) disable iff (rst)
        pin_pages |-> (mode_x == 3'd0 && mode_y == 3'd0)); // R9

    AST_NO_UNKNOWN_OUT: assert property (@(posedge clk) disable iff (rst)
        (mode_x != 3'd7 && mode_y != 3'd7)); // R9

endmodule

bind swz_unit swz_unit_chk #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .SZ_W(SZ_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tile_in   (tile_in),
    .fixup_in  (fixup_in),
    .addr_in   (addr_in),
    .cfg_sel   (cfg_sel),
    .ctl_word  (ctl_word),
    .size_a    (size_a),
    .size_b    (size_b),
    .addr_out  (addr_out),
    .mode_x    (mode_x),
    .mode_y    (mode_y),
    .pin_pages (pin_pages)
);

// File: tb/swz_unit_test.sv
module swz_unit_test;

    localparam int ADDR_W = 32;
    localparam int CTL_W  = 32;
    localparam int SZ_W   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic [1:0]        tile_in = 2'd0;
    logic              fixup_in = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              cfg_sel = 1'b0;
    logic [CTL_W-1:0]  ctl_word = '0;
    logic [SZ_W-1:0]   size_a = '0;
    logic [SZ_W-1:0]   size_b = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [2:0]        mode_x;
    logic [2:0]        mode_y;
    logic              pin_pages;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [2:0]        mx;
        logic [2:0]        my;
        logic              pin;
        string             tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    swz_unit #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .SZ_W(SZ_W)) uut (
        .clk(clk), .rst(rst), .en(en), .tile_in(tile_in), .fixup_in(fixup_in),
        .addr_in(addr_in), .cfg_sel(cfg_sel), .ctl_word(ctl_word),
        .size_a(size_a), .size_b(size_b), .addr_out(addr_out),
        .mode_x(mode_x), .mode_y(mode_y), .pin_pages(pin_pages)
    );

    // Reference model, written from the requirements
    function automatic item_t model(input logic e, input logic [1:0] t, input logic fx,
                                    input logic [ADDR_W-1:0] a, input logic s,
                                    input logic [CTL_W-1:0] c,
                                    input logic [SZ_W-1:0] sa, input logic [SZ_W-1:0] sbz);
        item_t r;
        logic [2:0] m;
        logic h;
        r.mx = 3'd0; r.my = 3'd0; r.pin = 1'b0;
        if (s) begin
            if (sa == sbz) begin r.mx = 3'd2; r.my = 3'd1; end
        end else if (c == '1) begin
            r.pin = 1'b1;
        end else begin
            case (c[1:0])
                2'd2: begin
                    if (c[10])     begin r.mx = 3'd2; r.my = 3'd1; end
                    else if (c[9]) begin r.mx = 3'd6; r.my = 3'd5; end
                    else           begin r.mx = 3'd4; r.my = 3'd3; end
                end
                2'd3: r.pin = 1'b1;
                default: ;
            endcase
        end
        m = (t == 2'd1) ? r.mx : (t == 2'd2) ? r.my : 3'd0;
        case (m)
            3'd1: h = a[9];
            3'd2: h = a[9] ^ a[10];
            3'd3: h = a[9] ^ a[11];
            3'd4: h = a[9] ^ a[10] ^ a[11];
            3'd5: h = a[9] ^ a[17];
            3'd6: h = a[9] ^ a[10] ^ a[17];
            default: h = 1'b0;
        endcase
        r.a = a;
        if (e) r.a[6] = a[6] ^ h ^ fx;
        r.tag = "";
        return r;
    endfunction

    task automatic drive(input logic e, input logic [1:0] t, input logic fx,
                         input logic [ADDR_W-1:0] a, input logic s,
                         input logic [CTL_W-1:0] c,
                         input logic [SZ_W-1:0] sa, input logic [SZ_W-1:0] sbz,
                         input string tag);
        item_t it;
        @(negedge clk);
        en = e; tile_in = t; fixup_in = fx; addr_in = a;
        cfg_sel = s; ctl_word = c; size_a = sa; size_b = sbz;
        it = model(e, t, fx, a, s, c, sa, sbz);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: each item is due just after the rising edge following its drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t exp_it;
                exp_it = sb.pop_front();
                checks++;
                if (addr_out !== exp_it.a || mode_x !== exp_it.mx ||
                    mode_y !== exp_it.my || pin_pages !== exp_it.pin) begin
                    errors++;
                    $display("FAIL %s: got addr=%h mx=%0d my=%0d pin=%0b, expected addr=%h mx=%0d my=%0d pin=%0b",
                             exp_it.tag, addr_out, mode_x, mode_y, pin_pages,
                             exp_it.a, exp_it.mx, exp_it.my, exp_it.pin);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1: reset state
        if (addr_out !== '0 || mode_x !== 3'd0 || mode_y !== 3'd0 || pin_pages !== 1'b0) begin
            errors++;
            $display("FAIL R1: got addr=%h mx=%0d my=%0d pin=%0b, expected all zero",
                     addr_out, mode_x, mode_y, pin_pages);
        end
        // Inputs changed while reset is held must not leak out
        addr_in = 32'hFFFF_FFFF; en = 1'b1; tile_in = 2'd1;
        @(negedge clk);
        checks++; // R1: still clear under reset with active inputs
        if (addr_out !== '0 || pin_pages !== 1'b0) begin
            errors++;
            $display("FAIL R1: got addr=%h pin=%0b under reset, expected 0 0", addr_out, pin_pages);
        end
        rst = 1'b0;

        drive(1, 2'd1, 0, 32'h0000_0600, 0, 32'h0, 0, 0, "R5 single channel");
        drive(1, 2'd2, 0, 32'h0000_0200, 0, 32'h1, 0, 0, "R5 asymmetric");
        drive(1, 2'd1, 0, 32'h0000_0200, 0, 32'h402, 0, 0, "R6 X bit9");
        drive(1, 2'd2, 0, 32'h0000_0600, 0, 32'h402, 0, 0, "R6 Y bit9");
        drive(1, 2'd1, 0, 32'h0000_0600, 0, 32'h402, 0, 0, "R6 X 9^10 cancel");
        drive(1, 2'd1, 0, 32'h0002_0800, 0, 32'h202, 0, 0, "R7 X 9_10_17");
        drive(1, 2'd1, 0, 32'h0000_0800, 0, 32'h002, 0, 0, "R7 X 9_10_11");
        drive(1, 2'd2, 0, 32'h0002_0000, 0, 32'h002, 0, 0, "R7 Y 9_11 ignores bit17");
        drive(1, 2'd2, 0, 32'h0002_0040, 0, 32'h202, 0, 0, "R7 Y 9_17");
        drive(1, 2'd1, 0, 32'h0000_0400, 1, 32'h0, 16'h0100, 16'h0100, "R8 equal sizes");
        drive(1, 2'd1, 0, 32'h0000_0400, 1, 32'h0, 16'h0100, 16'h0080, "R8 unequal sizes");
        drive(1, 2'd1, 0, 32'h0000_0200, 0, 32'hFFFF_FFFF, 0, 0, "R9 all ones readback");
        drive(1, 2'd2, 0, 32'h0000_0200, 0, 32'h3, 0, 0, "R9 reserved channel mode");
        drive(1, 2'd0, 0, 32'h0000_0200, 0, 32'h402, 0, 0, "R3 linear pass");
        drive(1, 2'd3, 0, 32'h0002_0E00, 0, 32'h202, 0, 0, "R3 reserved tile pass");
        drive(0, 2'd1, 1, 32'h0000_0200, 0, 32'h402, 0, 0, "R3 disabled pass");
        drive(1, 2'd0, 1, 32'h0000_1000, 0, 32'h0, 0, 0, "R10 fixup linear");
        drive(1, 2'd1, 1, 32'h0000_0200, 0, 32'h402, 0, 0, "R10 fixup on swizzle");
        drive(1, 2'd1, 0, 32'hDEAD_BEFF, 0, 32'h402, 0, 0, "R2 upper bits kept");

        // R4: back-to-back sweep of tap patterns over every interleave mode
        for (int i = 0; i < 48; i++) begin
            logic [ADDR_W-1:0] a;
            logic [CTL_W-1:0]  c;
            a = 32'h1234_0000 ^ (32'(i & 7) << 9) ^ (32'((i >> 3) & 1) << 17)
                ^ (32'(i & 1) << 6);
            case (i % 3)
                0: c = 32'h402;
                1: c = 32'h202;
                default: c = 32'h002;
            endcase
            drive(1, (i % 2 == 0) ? 2'd1 : 2'd2, 0, a, 0, c, 0, 0, "R4 tap sweep");
        end

        @(negedge clk);
        en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule